// File: doc/BRIEF.md
# Indexed Vertex Reuse Cache

This block walks through the vertices of one draw call and delivers a shaded record for each of them, in draw order. A draw is launched by a one-cycle `start` pulse that captures the vertex count, the draw kind and its operands. In a sequential draw the vertex number is the loop position added to a start offset. In an indexed draw the vertex number is read from an index array in memory, as bytes or as 16-bit little-endian halfwords.

For indexed draws, a small fully associative store remembers which vertex numbers were recently shaded and what the shader returned for them. Every tag is compared in a single cycle. A match returns the stored record without asking the shader. A miss sends one request to the shader. When the result comes back it is written into the slot named by a replacement pointer, which then steps on to the next slot in strict rotation. Sequential draws never look up or fill the store. Index fetch, shader request, shader response and the output stream are all external handshakes. One vertex is in flight at a time, so the output order always matches the index order.

Top module: `vtx_reuse_cache`

## Requirements
- R1: After reset, `busy`, `done`, `out_valid`, `sh_req_valid` and `ifetch_req` are all 0.
- R2: In a sequential draw (`idx_mode`=0), vertex k carries number `vtx_offset + k`, wrapping modulo 2^IDX_W. Every vertex is sent to the shader, and `out_hit` is 0 for all of them.
- R3: In an indexed draw with `wide_idx`=0, vertex k carries the byte at address `idx_base + k`, zero-extended to IDX_W bits. Bits 15:8 of `ifetch_data` have no effect.
- R4: In an indexed draw with `wide_idx`=1, vertex k carries the 16-bit value returned for address `idx_base + 2k`, with byte `idx_base+2k` as bits 7:0 and the next byte as bits 15:8. `vtx_offset` has no effect on indexed draws.
- R5: In an indexed draw, a vertex number that matches a valid stored tag is delivered with the stored record and `out_hit`=1. No shader request is issued for it.
- R6: On a miss, one shader request carrying the vertex number is issued. The response is delivered with `out_hit`=0. In an indexed draw the response is stored at the replacement pointer, which then advances by one modulo DEPTH. Hits do not move the pointer.
- R7: Every draw starts with all stored tags invalid and the replacement pointer at slot 0, so nothing is reused across draws.
- R8: Exactly `vtx_count` records leave on the output, in vertex order. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_index` and `out_data` hold steady. The same holding rule applies to pending shader requests and index fetches.
- R9: `done` is a one-cycle pulse raised the cycle after the last output handshake, or the cycle after `start` when `vtx_count` is 0. `busy` is high from the cycle after `start` until `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a draw (sampled only when idle) |
| idx_mode | input | 1 | 1 = indexed draw, 0 = sequential draw |
| wide_idx | input | 1 | 1 = 16-bit indices, 0 = 8-bit indices |
| vtx_count | input | CNT_W | Number of vertices in the draw |
| vtx_offset | input | IDX_W | First vertex number of a sequential draw |
| idx_base | input | ADDR_W | Byte address of the index array |
| busy | output | 1 | A draw is in progress |
| done | output | 1 | One-cycle end-of-draw pulse |
| ifetch_req | output | 1 | Index fetch request |
| ifetch_addr | output | ADDR_W | Byte address of the index being fetched |
| ifetch_ack | input | 1 | Fetch data valid; completes the fetch |
| ifetch_data | input | 16 | Two bytes starting at `ifetch_addr`, little-endian |
| sh_req_valid | output | 1 | Shader request valid |
| sh_req_ready | input | 1 | Shader accepts the request |
| sh_req_index | output | IDX_W | Vertex number to shade |
| sh_rsp_valid | input | 1 | Shader result valid |
| sh_rsp_data | input | DATA_W | Shaded record |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Consumer accepts the record |
| out_index | output | IDX_W | Vertex number of the record |
| out_data | output | DATA_W | Shaded record |
| out_hit | output | 1 | Record came from the store |

## Verification
The bench builds the block with DEPTH=4, 8-bit addresses, an 8-bit vertex count and 24-bit records. With only four slots, short index lists are enough to fill the store, wrap the replacement pointer and evict entries that were just hit. That makes the strict rotation visible within a dozen vertices. Each shader response tags its record with a running request serial, so a stale or misplaced entry shows up as a wrong record at the output. A sweep over both index widths, every count from 0 to 12 and several array bases runs under random stalls on all handshakes.

// File: rtl/vtx_reuse_cache.sv
module vtx_reuse_cache #(
  parameter int IDX_W  = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              idx_mode,
  input  logic              wide_idx,
  input  logic [CNT_W-1:0]  vtx_count,
  input  logic [IDX_W-1:0]  vtx_offset,
  input  logic [ADDR_W-1:0] idx_base,
  output logic              busy,
  output logic              done,
  output logic              ifetch_req,
  output logic [ADDR_W-1:0] ifetch_addr,
  input  logic              ifetch_ack,
  input  logic [15:0]       ifetch_data,
  output logic              sh_req_valid,
  input  logic              sh_req_ready,
  output logic [IDX_W-1:0]  sh_req_index,
  input  logic              sh_rsp_valid,
  input  logic [DATA_W-1:0] sh_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_index,
  output logic [DATA_W-1:0] out_data,
  output logic              out_hit
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOOK, S_SHADE, S_WAIT, S_EMIT} state_t;

  state_t            state;
  logic              mode_q, wide_q;
  logic [CNT_W-1:0]  count_q, cnt;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [DATA_W-1:0] cur_data;
  logic              cur_hit;
  logic [PTR_W-1:0]  ptr;

  logic [DEPTH-1:0]  val;
  logic [IDX_W-1:0]  tag [DEPTH];
  logic [DATA_W-1:0] rec [DEPTH];

  logic              hit;
  logic [PTR_W-1:0]  hit_slot;
  logic [IDX_W-1:0]  fetched;
  logic              last;
  logic              fill;

  always_comb begin
    hit = 1'b0;
    hit_slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (val[i] && tag[i] == cur_idx) begin
        hit = 1'b1;
        hit_slot = PTR_W'(i);
      end
    end
  end

  assign fetched = wide_q ? IDX_W'(ifetch_data) : IDX_W'(ifetch_data[7:0]);
  assign last    = (cnt == count_q - 1'b1);
  assign fill    = (state == S_WAIT) && sh_rsp_valid && mode_q;

  assign busy         = (state != S_IDLE);
  assign ifetch_req   = (state == S_FETCH);
  assign ifetch_addr  = addr;
  assign sh_req_valid = (state == S_SHADE);
  assign sh_req_index = cur_idx;
  assign out_valid    = (state == S_EMIT);
  assign out_index    = cur_idx;
  assign out_data     = cur_data;
  assign out_hit      = cur_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_q   <= 1'b0;
      wide_q   <= 1'b0;
      count_q  <= '0;
      cnt      <= '0;
      addr     <= '0;
      cur_idx  <= '0;
      cur_data <= '0;
      cur_hit  <= 1'b0;
      ptr      <= '0;
      val      <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            mode_q  <= idx_mode;
            wide_q  <= wide_idx;
            count_q <= vtx_count;
            cnt     <= '0;
            addr    <= idx_base;
            cur_idx <= vtx_offset;
            cur_hit <= 1'b0;
            ptr     <= '0;
            val     <= '0;
            if (vtx_count == '0) done <= 1'b1;
            else state <= idx_mode ? S_FETCH : S_SHADE;
          end
        end
        S_FETCH: begin
          if (ifetch_ack) begin
            cur_idx <= fetched;
            state   <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (hit) begin
            cur_data <= rec[hit_slot];
            cur_hit  <= 1'b1;
            state    <= S_EMIT;
          end else begin
            state <= S_SHADE;
          end
        end
        S_SHADE: begin
          if (sh_req_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (sh_rsp_valid) begin
            cur_data <= sh_rsp_data;
            cur_hit  <= 1'b0;
            state    <= S_EMIT;
            if (mode_q) begin
              val[ptr] <= 1'b1;
              ptr      <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
            end
          end
        end
        S_EMIT: begin
          if (out_ready) begin
            if (last) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              cnt  <= cnt + 1'b1;
              addr <= addr + (wide_q ? ADDR_W'(2) : ADDR_W'(1));
              if (mode_q) begin
                state <= S_FETCH;
              end else begin
                cur_idx <= cur_idx + 1'b1;
                state   <= S_SHADE;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag[ptr] <= cur_idx;
      rec[ptr] <= sh_rsp_data;
    end
  end
endmodule

module vtx_reuse_cache_chk #(
  parameter int IDX_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mode_q,
  input logic              ifetch_req,
  input logic              ifetch_ack,
  input logic [ADDR_W-1:0] ifetch_addr,
  input logic              sh_req_valid,
  input logic              sh_req_ready,
  input logic [IDX_W-1:0]  sh_req_index,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IDX_W-1:0]  out_index,
  input logic [DATA_W-1:0] out_data,
  input logic              out_hit
);
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_index) && $stable(out_data) && $stable(out_hit));

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sh_req_valid && !sh_req_ready |=> sh_req_valid && $stable(sh_req_index));

  a_r3_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ifetch_req && !ifetch_ack |=> ifetch_req && $stable(ifetch_addr));

  a_r3_fetch_indexed_only: assert property (@(posedge clk) disable iff (!rst_n)
    ifetch_req |-> mode_q);

  a_r2_no_hit_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> mode_q);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind vtx_reuse_cache vtx_reuse_cache_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mode_q(mode_q),
  .ifetch_req(ifetch_req), .ifetch_ack(ifetch_ack), .ifetch_addr(ifetch_addr),
  .sh_req_valid(sh_req_valid), .sh_req_ready(sh_req_ready), .sh_req_index(sh_req_index),
  .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
  .out_data(out_data), .out_hit(out_hit)
);

// File: tb/vtx_reuse_cache_bench.sv
module vtx_reuse_cache_bench;
  localparam int CLK_P  = 10;
  localparam int IDX_W  = 16;
  localparam int DATA_W = 24;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, idx_mode = 1'b0, wide_idx = 1'b0;
  logic [CNT_W-1:0]  vtx_count = '0;
  logic [IDX_W-1:0]  vtx_offset = '0;
  logic [ADDR_W-1:0] idx_base = '0;
  logic busy, done, ifetch_req, sh_req_valid, out_valid, out_hit;
  logic [ADDR_W-1:0] ifetch_addr;
  logic ifetch_ack = 1'b0;
  logic [15:0] ifetch_data = '0;
  logic sh_req_ready = 1'b0;
  logic [IDX_W-1:0] sh_req_index, out_index;
  logic sh_rsp_valid = 1'b0;
  logic [DATA_W-1:0] sh_rsp_data = '0;
  logic out_ready = 1'b0;
  logic [DATA_W-1:0] out_data;

  always #(CLK_P/2) clk = ~clk;

  vtx_reuse_cache #(.IDX_W(IDX_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_vtx_reuse_cache (
    .clk(clk), .rst_n(rst_n), .start(start), .idx_mode(idx_mode), .wide_idx(wide_idx),
    .vtx_count(vtx_count), .vtx_offset(vtx_offset), .idx_base(idx_base),
    .busy(busy), .done(done), .ifetch_req(ifetch_req), .ifetch_addr(ifetch_addr),
    .ifetch_ack(ifetch_ack), .ifetch_data(ifetch_data), .sh_req_valid(sh_req_valid),
    .sh_req_ready(sh_req_ready), .sh_req_index(sh_req_index), .sh_rsp_valid(sh_rsp_valid),
    .sh_rsp_data(sh_rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_index(out_index), .out_data(out_data), .out_hit(out_hit)
  );

  int errors = 0, checks = 0;
  logic [7:0] imem [256];
  logic [15:0] lf = 16'hACE1;

  // reference state for the running draw
  logic m_mode, m_wide;
  logic [IDX_W-1:0]  m_off;
  logic [ADDR_W-1:0] m_base;
  int vk = 0, reqs = 0, misses = 0;
  logic [IDX_W-1:0]  mtag [DEPTH];
  logic              mval [DEPTH];
  logic [DATA_W-1:0] mrec [DEPTH];
  int mptr = 0;
  int serial = 0;
  logic [DATA_W-1:0] last_rsp = '0;
  logic pend = 1'b0;
  int dly = 0;
  logic [IDX_W-1:0] pend_idx;
  logic stalled = 1'b0;
  logic [IDX_W-1:0] held_idx;
  logic [DATA_W-1:0] held_data;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [IDX_W-1:0] exp_idx(input int k);
    logic [ADDR_W-1:0] a;
    if (!m_mode) return m_off + IDX_W'(k);
    if (m_wide) begin
      a = m_base + ADDR_W'(2 * k);
      return IDX_W'({imem[a + 8'd1], imem[a]});
    end
    a = m_base + ADDR_W'(k);
    return IDX_W'(imem[a]);
  endfunction

  always @(negedge clk) begin
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    // index memory
    ifetch_ack  = ifetch_req && (lf[4] | lf[5]);
    ifetch_data = {imem[ifetch_addr + 8'd1], imem[ifetch_addr]};
    // shader
    sh_rsp_valid = 1'b0;
    if (pend) begin
      if (dly == 0) begin
        sh_rsp_data  = {serial[7:0], pend_idx};
        last_rsp     = sh_rsp_data;
        sh_rsp_valid = 1'b1;
        pend = 1'b0;
      end else dly--;
    end
    sh_req_ready = lf[2] | lf[3];
    if (sh_req_valid && sh_req_ready && !pend) begin
      chk(sh_req_index == exp_idx(vk), "R6", "shader request index", sh_req_index, exp_idx(vk));
      pend = 1'b1;
      dly = int'(lf[7:6]) % 3;
      pend_idx = sh_req_index;
      serial++;
      reqs++;
    end
    // output stream
    if (stalled)
      chk(out_valid && out_index == held_idx && out_data == held_data, "R8", "held record",
          {out_valid, out_index, out_data}, {1'b1, held_idx, held_data});
    out_ready = lf[0] | lf[1];
    stalled = out_valid && !out_ready;
    held_idx = out_index;
    held_data = out_data;
    if (out_valid && out_ready) begin
      logic [IDX_W-1:0] ei;
      int hs;
      ei = exp_idx(vk);
      chk(out_index == ei, m_mode ? (m_wide ? "R4" : "R3") : "R2", "vertex number", out_index, ei);
      hs = -1;
      if (m_mode) for (int i = 0; i < DEPTH; i++) if (mval[i] && mtag[i] == ei) hs = i;
      if (hs >= 0) begin
        chk(out_hit == 1'b1, "R5", "hit flag", out_hit, 1);
        chk(out_data == mrec[hs], "R5", "stored record", out_data, mrec[hs]);
      end else begin
        misses++;
        chk(out_hit == 1'b0, m_mode ? "R6" : "R2", "miss flag", out_hit, 0);
        chk(out_data == last_rsp, "R6", "shaded record", out_data, last_rsp);
        if (m_mode) begin
          mtag[mptr] = ei; mval[mptr] = 1'b1; mrec[mptr] = last_rsp;
          mptr = (mptr + 1) % DEPTH;
        end
      end
      vk++;
    end
  end

  task automatic run_draw(input bit im, input bit wd, input int n, input int off, input int base);
    int wait_c;
    @(negedge clk);
    m_mode = im; m_wide = wd; m_off = IDX_W'(off); m_base = ADDR_W'(base);
    vk = 0; reqs = 0; misses = 0; mptr = 0;
    for (int i = 0; i < DEPTH; i++) mval[i] = 1'b0;   // R7: reference starts empty
    idx_mode = im; wide_idx = wd; vtx_count = CNT_W'(n);
    vtx_offset = IDX_W'(off); idx_base = ADDR_W'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == (n != 0), "R9", "busy after start", busy, n != 0);
    wait_c = 0;
    while (!done && wait_c < 3000) begin
      @(negedge clk);
      wait_c++;
    end
    chk(done == 1'b1, "R9", "done raised", done, 1);
    chk(vk == n, "R8", "records delivered", vk, n);
    chk(reqs == misses, "R5", "shader requests equal misses", reqs, misses);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", "done single pulse", {done, busy}, 0);
  endtask

  task automatic put16(input int a, input int v);
    imem[a[7:0]] = v[7:0];
    imem[8'(a + 1)] = v[15:8];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) imem[i] = 8'((i * 5 + i / 3) % 6);
    repeat (3) @(negedge clk);
    chk({busy, done, out_valid, sh_req_valid, ifetch_req} == 5'b0, "R1", "reset outputs",
        {busy, done, out_valid, sh_req_valid, ifetch_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, out_valid, sh_req_valid, ifetch_req} == 5'b0, "R1", "idle after reset",
        {busy, done, out_valid, sh_req_valid, ifetch_req}, 0);

    // R2: sequential draw wrapping past the top of the index range
    run_draw(1'b0, 1'b0, 10, 16'hFFFC, 0);

    // R3: byte indices with repeats, high byte of fetch data is junk; offset ignored
    begin
      int l8 [10] = '{3, 5, 3, 7, 5, 9, 3, 11, 13, 3};
      for (int i = 0; i < 10; i++) imem[8'h10 + i] = 8'(l8[i]);
      imem[8'h1A] = 8'hEE;
    end
    run_draw(1'b1, 1'b0, 10, 16'h1234, 8'h10);
    // R7: identical draw again starts from an empty store
    run_draw(1'b1, 1'b0, 10, 16'h0000, 8'h10);

    // R4: halfword indices whose low bytes collide
    put16(8'h40, 16'h1203); put16(8'h42, 16'h0003); put16(8'h44, 16'h1203);
    put16(8'h46, 16'hABCD); put16(8'h48, 16'h0003); put16(8'h4A, 16'hABCD);
    run_draw(1'b1, 1'b1, 6, 16'h7777, 8'h40);

    // R6: strict rotation evicts a slot that was just hit
    begin
      int lr [9] = '{1, 2, 3, 4, 1, 5, 1, 2, 4};
      for (int i = 0; i < 9; i++) imem[8'h60 + i] = 8'(lr[i]);
    end
    run_draw(1'b1, 1'b0, 9, 0, 8'h60);

    // R9: empty draw
    run_draw(1'b1, 1'b0, 0, 0, 0);
    run_draw(1'b0, 1'b0, 0, 5, 0);

    // sweep: both widths, counts 0..12, several bases, index array wrapping the address space
    for (int i = 0; i < 256; i++) if (i < 8'h10 || i >= 8'h80) imem[i] = 8'((i * 5 + i / 3) % 6);
    for (int w = 0; w < 2; w++)
      for (int n = 0; n <= 12; n++)
        for (int b = 0; b < 3; b++)
          run_draw(1'b1, w[0], n, 16'h0100 * b, (b == 2) ? 8'hF8 : 8'h80 + 8'(b * 7));
    for (int n = 1; n <= 6; n++) run_draw(1'b0, 1'b0, n, 16'h00F0 + n, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule